// File: doc/BRIEF.md
# Push-Button Conditioner

This block turns one raw, asynchronous push-button signal into clean synchronous signals. The raw input first passes through a chain of flip-flops that brings it into the clock domain. A hysteresis filter follows. Its counter runs only while the synchronised input disagrees with the filtered level it currently presents. The filtered level takes the new value only after the disagreement has held for `HOLD_CYCLES` consecutive clocks. Any shorter disagreement, such as contact chatter, clears the counter, and the level does not change.

An edge detector watches the filtered level. It produces one-cycle pulses on a rising transition, on a falling transition, and on either transition. All outputs are plain level or pulse pins. There is no data stream, so no valid/ready handshake is used, and downstream logic samples the pins every cycle. The synchroniser depth (`SYNC_STAGES`, default 3) and the hold count (`HOLD_CYCLES`, default 4, at least 1) are parameters. The counter width is derived from `HOLD_CYCLES`.

Top module: `btn_conditioner`

## Requirements
- R1: The raw input reaches the filter through `SYNC_STAGES` flip-flops. A change at the raw input is seen by the filter after the third rising edge (default depth).
- R2: The hold counter advances only while the synchronised input differs from `level`. It is zero in every cycle that follows a cycle in which the two agree.
- R3: `level` changes only after `HOLD_CYCLES` consecutive clocks of disagreement. With the defaults, a stable raw change becomes visible on `level` after the 7th rising edge following it.
- R4: A disagreement that lasts fewer than `HOLD_CYCLES` clocks leaves `level` unchanged, whether it is a short press, a short release or repeated chatter.
- R5: The counter returns to zero in the same cycle that `level` flips, so a flip back needs another full `HOLD_CYCLES` run.
- R6: `rise_pulse` is high for exactly one cycle, in the cycle after the edge where `level` goes from 0 to 1.
- R7: `fall_pulse` is high for exactly one cycle, in the cycle after the edge where `level` goes from 1 to 0.
- R8: `edge_pulse` is the OR of `rise_pulse` and `fall_pulse`. Those two are never high together.
- R9: While `rst` (synchronous, active high) is asserted, the synchroniser, counter, `level` and edge history are cleared to 0, and no pulse appears during reset or in the first cycle after it. Once reset is released, the block works normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| button_raw | input | 1 | Asynchronous button input, 1 = pressed |
| level | output | 1 | Filtered button level |
| rise_pulse | output | 1 | One-cycle pulse on a 0 to 1 change of `level` |
| fall_pulse | output | 1 | One-cycle pulse on a 1 to 0 change of `level` |
| edge_pulse | output | 1 | One-cycle pulse on either change of `level` |

## Verification
The assertions assume two things about the inputs. First, `rst` is high from time zero for at least one rising edge, so every stage and the history register hold a known value before any `$past` comparison counts. Second, `HOLD_CYCLES` is at least 1. The stimulus changes `button_raw` only on falling clock edges and starts with reset asserted. This keeps the synchroniser free of metastability in simulation, so the three-cycle latency is exact and the expected edge numbers hold.

// File: rtl/btn_cond_pkg.sv
package btn_cond_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
    logic any;
  } edge_pulses_t;

  function automatic int hold_cnt_width(input int hold);
    return (hold <= 2) ? 1 : $clog2(hold);
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

  // R1: each stage repeats the previous one a cycle later
  for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
    a_r1_stage_shift : assert property (@(posedge clk) disable iff (rst)
      chain_q[g] == $past(chain_q[g-1]));
  end
endmodule

// File: rtl/btn_filter.sv
module btn_filter #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  import btn_cond_pkg::*;

  localparam int CW = hold_cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differ;

  assign differ = (din != level_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (!differ) begin
      cnt_q   <= '0;
    end else if (cnt_q == LAST) begin
      level_q <= din;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign level = level_q;

  a_r2_idle_clear : assert property (@(posedge clk) disable iff (rst)
    (din == level_q) |=> (cnt_q == '0));

  a_r2_count_step : assert property (@(posedge clk) disable iff (rst)
    (differ && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r3_flip_after_run : assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> ($past(cnt_q) == LAST && $past(differ)));

  a_r5_zero_on_flip : assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/btn_edge.sv
module btn_edge (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       level,
  output btn_cond_pkg::edge_pulses_t pulses
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  always_comb begin
    pulses.rise = level & ~prev_q;
    pulses.fall = ~level & prev_q;
    pulses.any  = pulses.rise | pulses.fall;
  end

  a_r6_rise_single : assert property (@(posedge clk) disable iff (rst)
    pulses.rise |=> !pulses.rise);

  a_r6_rise_on_change : assert property (@(posedge clk) disable iff (rst)
    (level && !$past(level)) |-> pulses.rise);

  a_r7_fall_single : assert property (@(posedge clk) disable iff (rst)
    pulses.fall |=> !pulses.fall);

  a_r7_fall_on_change : assert property (@(posedge clk) disable iff (rst)
    (!level && $past(level)) |-> pulses.fall);

  a_r8_exclusive : assert property (@(posedge clk) disable iff (rst)
    $onehot0({pulses.rise, pulses.fall}));
endmodule

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int SYNC_STAGES = 3,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic button_raw,
  output logic level,
  output logic rise_pulse,
  output logic fall_pulse,
  output logic edge_pulse
);
  import btn_cond_pkg::*;

  logic         synced;
  logic         level_w;
  edge_pulses_t pulses;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (button_raw),
    .dout (synced)
  );

  btn_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_filter (
    .clk   (clk),
    .rst   (rst),
    .din   (synced),
    .level (level_w)
  );

  btn_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .level  (level_w),
    .pulses (pulses)
  );

  assign level      = level_w;
  assign rise_pulse = pulses.rise;
  assign fall_pulse = pulses.fall;
  assign edge_pulse = pulses.any;

  a_r9_quiet_after_reset : assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!edge_pulse && !level));

  a_r8_any_matches : assert property (@(posedge clk) disable iff (rst)
    edge_pulse == (rise_pulse || fall_pulse));
endmodule

// File: tb/btn_conditioner_test.sv
module btn_conditioner_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic button_raw = 1'b0;
  logic level, rise_pulse, fall_pulse, edge_pulse;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  int falls  = 0;
  int anys   = 0;
  int both   = 0;

  btn_conditioner uut (
    .clk        (clk),
    .rst        (rst),
    .button_raw (button_raw),
    .level      (level),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse),
    .edge_pulse (edge_pulse)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (rise_pulse) rises++;
      if (fall_pulse) falls++;
      if (edge_pulse) anys++;
      if (rise_pulse && fall_pulse) both++;
    end
  end

  // {button, wait cycles[7:1], expected level}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 7'd3,  1'b0},  // R4 short press
    {1'b0, 7'd12, 1'b0},  // R4 rejected
    {1'b1, 7'd12, 1'b1},  // R3 press accepted
    {1'b0, 7'd2,  1'b1},  // R4 short release
    {1'b1, 7'd12, 1'b1},  // R4 release rejected
    {1'b0, 7'd12, 1'b0},  // R3 release accepted
    {1'b1, 7'd1,  1'b0},  // R4 chatter
    {1'b0, 7'd1,  1'b0},
    {1'b1, 7'd1,  1'b0},
    {1'b0, 7'd12, 1'b0},  // R4 chatter rejected
    {1'b1, 7'd4,  1'b0},  // R3 pulse exactly HOLD long
    {1'b0, 7'd12, 1'b0},  // R5 flips up then back down
    {1'b1, 7'd12, 1'b1},  // R3
    {1'b0, 7'd12, 1'b0}   // R3
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int r0, f0, a0;
    // R9 reset state
    step(3);
    chk("R9 level in reset", level, 1'b0);
    chk("R9 edge in reset", edge_pulse, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R9 no pulse after reset", edge_pulse, 1'b0);
    chk("R9 level after reset", level, 1'b0);
    step(10);

    // table walk: R3 R4 R5 R6 R7 R8
    r0 = rises; f0 = falls; a0 = anys;
    for (int i = 0; i < NV; i++) begin
      button_raw = VEC[i][8];
      step(int'(VEC[i][7:1]));
      chk($sformatf("R3/R4/R5 vector %0d level", i), level, VEC[i][0]);
    end
    chk_int("R6 rise pulse count", rises - r0, 3);
    chk_int("R7 fall pulse count", falls - f0, 3);
    chk_int("R8 any pulse count", anys - a0, 6);
    chk_int("R8 rise and fall together", both, 0);

    // R1 R3 exact press latency, R6 R8 pulse shape
    button_raw = 1'b1;
    step(6);
    chk("R3 level before 7th edge", level, 1'b0);
    chk("R6 no rise yet", rise_pulse, 1'b0);
    step(1);
    chk("R1 level after 7th edge", level, 1'b1);
    chk("R6 rise pulse", rise_pulse, 1'b1);
    chk("R8 any on rise", edge_pulse, 1'b1);
    chk("R8 no fall on rise", fall_pulse, 1'b0);
    step(1);
    chk("R6 rise one cycle", rise_pulse, 1'b0);
    chk("R8 any one cycle", edge_pulse, 1'b0);

    // R7 release latency and fall pulse
    step(10);
    button_raw = 1'b0;
    step(6);
    chk("R3 level held before 7th edge", level, 1'b1);
    step(1);
    chk("R3 level released", level, 1'b0);
    chk("R7 fall pulse", fall_pulse, 1'b1);
    chk("R8 any on fall", edge_pulse, 1'b1);
    chk("R8 no rise on fall", rise_pulse, 1'b0);
    step(1);
    chk("R7 fall one cycle", fall_pulse, 1'b0);

    // R5 counter restarts from zero on a flip
    step(10);
    button_raw = 1'b1;
    step(4);
    button_raw = 1'b0;
    step(3);
    chk("R5 level up at edge 7", level, 1'b1);
    step(3);
    chk("R5 level still up at edge 10", level, 1'b1);
    step(1);
    chk("R5 level down at edge 11", level, 1'b0);

    // R9 reset while pressed
    step(10);
    button_raw = 1'b1;
    step(12);
    chk("R9 pressed before reset", level, 1'b1);
    rst = 1'b1;
    step(1);
    chk("R9 level cleared by reset", level, 1'b0);
    chk("R9 no fall on reset", fall_pulse, 1'b0);
    step(2);
    rst = 1'b0;
    step(1);
    chk("R9 quiet first cycle", edge_pulse, 1'b0);
    step(6);
    chk("R9 recovers after reset", level, 1'b1);

    finish_run();
  end
endmodule